// File: doc/BRIEF.md
# Receive Frame Accept/Drop Filter

This block sits in a receive path and watches a byte-wide frame stream that carries start and end markers. It also watches a CRC-error flag and an upstream truncation flag, both valid on the last byte of a frame. Every byte of an accepted frame goes into a store-and-forward buffer. At the last byte, the filter decides whether to keep the frame or discard it. It bases that decision on the CRC status, a destination-address check against one programmable station address, pause-frame detection, and frame length. A kept frame is released to the output as one unbroken burst. A discarded frame is rewound out of the buffer and never reaches the output.

For every frame it observes, the block raises a one-cycle event strobe for a statistics collector. The strobe carries the verdict (forwarded or dropped), the class flags (CRC error, pause, broadcast, multicast) and the frame's total byte count. Configuration inputs select the following:
- whether CRC errors cause a drop,
- promiscuous acceptance of unicast frames,
- promiscuous acceptance of multicast frames,
- pass-through of pause frames,
- removal of the 4-byte FCS from forwarded frames,
- the largest allowed payload.

Top module: `rx_accept_filter`

## Requirements
- R1: After reset, out_valid and ev_valid are low and stay low until a frame is presented.
- R2: An accepted frame leaves on out_data byte for byte in arrival order, with out_sof on the first byte and out_eof on the last. ev_valid is high for exactly the cycle after the clock edge that samples the end-marker byte, and in that cycle ev_ok=1, ev_drop=0 and ev_bytes equals the frame's total byte count.
- R3: With cfg_strip_fcs=1, a forwarded frame omits its final 4 bytes, and out_eof marks the byte before them. ev_bytes still reports the full length.
- R4: in_crc_err=1 on the end byte sets ev_crc. The frame is dropped if cfg_crc_chk_off=0 and forwarded (if otherwise acceptable) if cfg_crc_chk_off=1.
- R5: in_trunc=1 on the end byte is handled exactly like a CRC error: ev_crc is set and the frame is dropped while CRC checking is on.
- R6: The destination is bytes 0..5, byte 0 holding address bits 47:40. A unicast frame (byte 0 bit 0 clear) is dropped unless its destination equals cfg_station or cfg_promisc_uc=1.
- R7: A multicast frame (byte 0 bit 0 set, not all ones) sets ev_mcast and is dropped unless cfg_promisc_mc=1. A broadcast frame (all 48 bits set) sets ev_bcast, not ev_mcast, and always passes the address check.
- R8: A pause frame (bytes 12..13 = 0x8808 and bytes 14..15 = 0x0001) sets ev_pause. It skips the address check and is dropped unless cfg_pass_pause=1. Type 0x8808 with any other opcode is not a pause frame.
- R9: With L the total byte count including header and FCS, a frame is dropped when L < 64 or L > cfg_max_len + 18.
- R10: A frame is taken only if cfg_en=1 on its start byte. A frame started while disabled produces no output and no event. Clearing cfg_en in mid-frame does not affect the frame in progress.
- R11: A dropped frame produces no output byte. The buffer never holds more than its capacity, and a frame that does not fit is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_crc_err | input | 1 | Bad CRC, sampled with in_eof |
| in_trunc | input | 1 | Frame cut short upstream, sampled with in_eof |
| cfg_en | input | 1 | Accept new frames |
| cfg_crc_chk_off | input | 1 | Forward frames despite CRC errors |
| cfg_promisc_uc | input | 1 | Accept every unicast destination |
| cfg_promisc_mc | input | 1 | Accept every multicast destination |
| cfg_pass_pause | input | 1 | Forward pause frames |
| cfg_strip_fcs | input | 1 | Remove 4 FCS bytes on output |
| cfg_max_len | input | 14 | Largest payload in bytes |
| cfg_station | input | 48 | Station address |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_sof | output | 1 | First output byte of a frame |
| out_eof | output | 1 | Last output byte of a frame |
| ev_valid | output | 1 | Per-frame event strobe |
| ev_ok | output | 1 | Frame forwarded |
| ev_drop | output | 1 | Frame dropped |
| ev_crc | output | 1 | CRC error or truncation |
| ev_pause | output | 1 | Pause frame |
| ev_bcast | output | 1 | Broadcast destination |
| ev_mcast | output | 1 | Multicast destination |
| ev_bytes | output | 16 | Total frame byte count |

## Verification
The assertions assume that the configuration inputs stay fixed from a frame's end byte to the following cycle. They also assume that the sink never stalls, because the output has no ready signal. The stimulus changes configuration only between frames, with one exception: cfg_en, which the enable scenario drops deliberately in mid-frame. It waits for each forwarded burst to drain before presenting the next frame. Frames are kept well below the buffer capacity, so the only overflow path exercised is the one the capacity assertion guards.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    typedef struct packed {
        logic ok;
        logic drop;
        logic crc;
        logic pause;
        logic bcast;
        logic mcast;
    } rxf_evt_t;

    localparam logic [15:0] RXF_FLOW_TYPE   = 16'h8808;
    localparam logic [15:0] RXF_PAUSE_OPCODE = 16'h0001;
endpackage

// File: rtl/rxf_classifier.sv
module rxf_classifier
    import rxf_pkg::*;
#(
    parameter int LEN_W   = 16,
    parameter int MAX_W   = 14,
    parameter int MIN_LEN = 64,
    parameter int HDR_FCS = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic              in_crc_err,
    input  logic              in_trunc,
    input  logic              cfg_en,
    input  logic              cfg_crc_chk_off,
    input  logic              cfg_promisc_uc,
    input  logic              cfg_promisc_mc,
    input  logic              cfg_pass_pause,
    input  logic              cfg_strip_fcs,
    input  logic [MAX_W-1:0]  cfg_max_len,
    input  logic [47:0]       cfg_station,
    input  logic              buf_ok,
    output logic              wr_start,
    output logic              wr_en,
    output logic [7:0]        wr_data,
    output logic              end_valid,
    output logic              end_keep,
    output logic [LEN_W-1:0]  end_len,
    output logic              end_strip,
    output logic              ev_valid,
    output rxf_evt_t          ev_flags,
    output logic [LEN_W-1:0]  ev_bytes
);
    localparam int CW = LEN_W + 1;

    typedef struct packed {
        logic             in_frame;
        logic [LEN_W-1:0] cnt;
        logic [47:0]      da;
        logic [15:0]      etype;
        logic [15:0]      opcode;
        logic             ev_valid;
        rxf_evt_t         ev;
        logic [LEN_W-1:0] ev_bytes;
    } cls_state_t;

    cls_state_t s_q, s_d;

    logic             beat_ok;
    logic [LEN_W-1:0] idx;
    logic             is_bc, is_mc, is_pause, crc_bad, addr_ok, len_ok, keep;

    always_comb begin
        s_d          = s_q;
        s_d.ev_valid = 1'b0;
        beat_ok      = in_valid && (in_sof ? cfg_en : s_q.in_frame);
        idx          = in_sof ? '0 : s_q.cnt;

        if (beat_ok) begin
            if (in_sof) begin
                s_d.da     = '0;
                s_d.etype  = '0;
                s_d.opcode = '0;
            end
            for (int k = 0; k < 6; k++) begin
                if (idx == LEN_W'(k)) s_d.da[8*(5-k) +: 8] = in_data;
            end
            if (idx == LEN_W'(12)) s_d.etype[15:8]  = in_data;
            if (idx == LEN_W'(13)) s_d.etype[7:0]   = in_data;
            if (idx == LEN_W'(14)) s_d.opcode[15:8] = in_data;
            if (idx == LEN_W'(15)) s_d.opcode[7:0]  = in_data;
            s_d.cnt      = (idx == '1) ? idx : idx + LEN_W'(1);
            s_d.in_frame = !in_eof;
        end

        is_bc    = &s_d.da;
        is_mc    = s_d.da[40] && !is_bc;
        is_pause = (s_d.etype == RXF_FLOW_TYPE) && (s_d.opcode == RXF_PAUSE_OPCODE);
        crc_bad  = in_crc_err || in_trunc;
        if (is_bc || is_pause) addr_ok = 1'b1;
        else if (is_mc)        addr_ok = cfg_promisc_mc;
        else                   addr_ok = cfg_promisc_uc || (s_d.da == cfg_station);
        len_ok   = ({1'b0, s_d.cnt} >= CW'(MIN_LEN)) &&
                   ({1'b0, s_d.cnt} <= CW'(cfg_max_len) + CW'(HDR_FCS));
        keep     = !(crc_bad && !cfg_crc_chk_off) && addr_ok &&
                   (!is_pause || cfg_pass_pause) && len_ok && buf_ok;

        if (beat_ok && in_eof) begin
            s_d.ev_valid = 1'b1;
            s_d.ev.ok    = keep;
            s_d.ev.drop  = !keep;
            s_d.ev.crc   = crc_bad;
            s_d.ev.pause = is_pause;
            s_d.ev.bcast = is_bc;
            s_d.ev.mcast = is_mc;
            s_d.ev_bytes = s_d.cnt;
        end

        wr_start  = beat_ok && in_sof;
        wr_en     = beat_ok;
        wr_data   = in_data;
        end_valid = beat_ok && in_eof;
        end_keep  = keep;
        end_len   = s_d.cnt;
        end_strip = cfg_strip_fcs;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ev_valid = s_q.ev_valid;
    assign ev_flags = s_q.ev;
    assign ev_bytes = s_q.ev_bytes;

    // a forwarded frame is never a runt
    assert_len_floor_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid && ev_flags.ok |-> ev_bytes >= LEN_W'(MIN_LEN));
    // a forwarded frame with bad CRC implies checking was off at its end byte
    assert_crc_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid && ev_flags.ok && ev_flags.crc |-> $past(cfg_crc_chk_off));
    // a forwarded pause frame implies pass-through was on
    assert_pause_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid && ev_flags.ok && ev_flags.pause |-> $past(cfg_pass_pause));
endmodule

// File: rtl/rxf_sf_buffer.sv
module rxf_sf_buffer #(
    parameter int DEPTH  = 2048,
    parameter int NDESC  = 4,
    parameter int LEN_W  = 16,
    parameter int FCS_B  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_start,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic             end_valid,
    input  logic             end_keep,
    input  logic [LEN_W-1:0] end_len,
    input  logic             end_strip,
    output logic             buf_ok,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             out_sof,
    output logic             out_eof
);
    localparam int AW = $clog2(DEPTH);
    localparam int DW = $clog2(NDESC);

    typedef struct packed {
        logic [AW:0]      wr_ptr;
        logic [AW:0]      commit;
        logic [AW:0]      rd_ptr;
        logic             ovf;
        logic [DW:0]      dwr;
        logic [DW:0]      drd;
        logic             busy;
        logic             strip;
        logic [LEN_W-1:0] remain;
        logic             first;
        logic             o_valid;
        logic [7:0]       o_data;
        logic             o_sof;
        logic             o_eof;
    } buf_state_t;

    buf_state_t s_q, s_d;

    logic [7:0]       mem   [DEPTH];
    logic [LEN_W-1:0] d_len [NDESC];
    logic             d_strip [NDESC];

    logic [AW:0] wcur, used;
    logic        full, dfull, ovf_cur, mem_we, desc_we;

    always_comb begin
        s_d     = s_q;
        wcur    = wr_start ? s_q.commit : s_q.wr_ptr;
        used    = wcur - s_q.rd_ptr;
        full    = (used == (AW+1)'(DEPTH));
        dfull   = ((s_q.dwr - s_q.drd) == (DW+1)'(NDESC));
        ovf_cur = (wr_start ? 1'b0 : s_q.ovf) || (wr_en && full);
        buf_ok  = !ovf_cur && !dfull;
        mem_we  = wr_en && !full;
        desc_we = end_valid && end_keep;

        if (wr_en) begin
            s_d.wr_ptr = wcur + (AW+1)'(mem_we);
            s_d.ovf    = ovf_cur;
        end
        if (end_valid) begin
            if (end_keep) begin
                s_d.commit = s_d.wr_ptr;
                s_d.dwr    = s_q.dwr + (DW+1)'(1);
            end else begin
                s_d.wr_ptr = s_q.commit;
            end
        end

        s_d.o_valid = 1'b0;
        s_d.o_sof   = 1'b0;
        s_d.o_eof   = 1'b0;
        if (s_q.busy) begin
            s_d.o_valid = 1'b1;
            s_d.o_data  = mem[s_q.rd_ptr[AW-1:0]];
            s_d.o_sof   = s_q.first;
            s_d.o_eof   = (s_q.remain == LEN_W'(1));
            s_d.first   = 1'b0;
            s_d.remain  = s_q.remain - LEN_W'(1);
            s_d.rd_ptr  = s_q.rd_ptr + (AW+1)'(1);
            if (s_q.remain == LEN_W'(1)) begin
                s_d.busy   = 1'b0;
                s_d.rd_ptr = s_q.rd_ptr + (AW+1)'(1) +
                             (s_q.strip ? (AW+1)'(FCS_B) : '0);
            end
        end else if (s_q.dwr != s_q.drd) begin
            s_d.busy   = 1'b1;
            s_d.first  = 1'b1;
            s_d.strip  = d_strip[s_q.drd[DW-1:0]];
            s_d.remain = d_strip[s_q.drd[DW-1:0]] ?
                         d_len[s_q.drd[DW-1:0]] - LEN_W'(FCS_B) :
                         d_len[s_q.drd[DW-1:0]];
            s_d.drd    = s_q.drd + (DW+1)'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (mem_we) mem[wcur[AW-1:0]] <= wr_data;
        if (desc_we) begin
            d_len[s_q.dwr[DW-1:0]]   <= end_len;
            d_strip[s_q.dwr[DW-1:0]] <= end_strip;
        end
    end

    assign out_valid = s_q.o_valid;
    assign out_data  = s_q.o_data;
    assign out_sof   = s_q.o_sof;
    assign out_eof   = s_q.o_eof;

    // occupancy never passes capacity
    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.wr_ptr - s_q.rd_ptr) <= (AW+1)'(DEPTH));
    // back-to-back output frames are separated by an end marker
    assert_sof_after_eof_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_sof && $past(out_valid) |-> $past(out_eof));
    // an end marker is followed by a start marker or idle
    assert_eof_then_sof_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_eof |=> !out_valid || out_sof);
endmodule

// File: rtl/rx_accept_filter.sv
module rx_accept_filter
    import rxf_pkg::*;
#(
    parameter int DEPTH   = 2048,
    parameter int NDESC   = 4,
    parameter int LEN_W   = 16,
    parameter int MAX_W   = 14,
    parameter int MIN_LEN = 64,
    parameter int HDR_FCS = 18,
    parameter int FCS_B   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_sof,
    input  logic             in_eof,
    input  logic             in_crc_err,
    input  logic             in_trunc,
    input  logic             cfg_en,
    input  logic             cfg_crc_chk_off,
    input  logic             cfg_promisc_uc,
    input  logic             cfg_promisc_mc,
    input  logic             cfg_pass_pause,
    input  logic             cfg_strip_fcs,
    input  logic [MAX_W-1:0] cfg_max_len,
    input  logic [47:0]      cfg_station,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             out_sof,
    output logic             out_eof,
    output logic             ev_valid,
    output logic             ev_ok,
    output logic             ev_drop,
    output logic             ev_crc,
    output logic             ev_pause,
    output logic             ev_bcast,
    output logic             ev_mcast,
    output logic [LEN_W-1:0] ev_bytes
);
    logic             wr_start, wr_en, end_valid, end_keep, end_strip, buf_ok;
    logic [7:0]       wr_data;
    logic [LEN_W-1:0] end_len;
    rxf_evt_t         ev_flags;

    rxf_classifier #(
        .LEN_W(LEN_W), .MAX_W(MAX_W), .MIN_LEN(MIN_LEN), .HDR_FCS(HDR_FCS)
    ) u_cls (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
        .in_crc_err(in_crc_err), .in_trunc(in_trunc),
        .cfg_en(cfg_en), .cfg_crc_chk_off(cfg_crc_chk_off),
        .cfg_promisc_uc(cfg_promisc_uc), .cfg_promisc_mc(cfg_promisc_mc),
        .cfg_pass_pause(cfg_pass_pause), .cfg_strip_fcs(cfg_strip_fcs),
        .cfg_max_len(cfg_max_len), .cfg_station(cfg_station),
        .buf_ok(buf_ok),
        .wr_start(wr_start), .wr_en(wr_en), .wr_data(wr_data),
        .end_valid(end_valid), .end_keep(end_keep), .end_len(end_len),
        .end_strip(end_strip),
        .ev_valid(ev_valid), .ev_flags(ev_flags), .ev_bytes(ev_bytes)
    );

    rxf_sf_buffer #(
        .DEPTH(DEPTH), .NDESC(NDESC), .LEN_W(LEN_W), .FCS_B(FCS_B)
    ) u_buf (
        .clk(clk), .rst_n(rst_n),
        .wr_start(wr_start), .wr_en(wr_en), .wr_data(wr_data),
        .end_valid(end_valid), .end_keep(end_keep), .end_len(end_len),
        .end_strip(end_strip), .buf_ok(buf_ok),
        .out_valid(out_valid), .out_data(out_data),
        .out_sof(out_sof), .out_eof(out_eof)
    );

    assign ev_ok    = ev_flags.ok;
    assign ev_drop  = ev_flags.drop;
    assign ev_crc   = ev_flags.crc;
    assign ev_pause = ev_flags.pause;
    assign ev_bcast = ev_flags.bcast;
    assign ev_mcast = ev_flags.mcast;
endmodule

// File: tb/rx_accept_filter_test.sv
module rx_accept_filter_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 0, in_sof = 0, in_eof = 0, in_crc_err = 0, in_trunc = 0;
    logic [7:0] in_data = '0;
    logic cfg_en = 1, cfg_crc_chk_off = 0, cfg_promisc_uc = 0, cfg_promisc_mc = 0;
    logic cfg_pass_pause = 0, cfg_strip_fcs = 0;
    logic [13:0] cfg_max_len = 14'd1500;
    logic [47:0] cfg_station = 48'h02_11_22_33_44_55;
    logic out_valid, out_sof, out_eof;
    logic [7:0] out_data;
    logic ev_valid, ev_ok, ev_drop, ev_crc, ev_pause, ev_bcast, ev_mcast;
    logic [15:0] ev_bytes;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [7:0] frm[$];
    logic [7:0] got[$];
    bit got_sof[$];
    bit got_eof[$];

    localparam logic [47:0] STA   = 48'h02_11_22_33_44_55;
    localparam logic [47:0] OTHER = 48'h02_11_22_33_44_56;
    localparam logic [47:0] MCAST = 48'h01_00_5E_00_00_07;
    localparam logic [47:0] BCAST = 48'hFF_FF_FF_FF_FF_FF;
    localparam logic [47:0] PDA   = 48'h01_80_C2_00_00_01;

    always #10 clk = ~clk;

    rx_accept_filter uut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
        .in_crc_err(in_crc_err), .in_trunc(in_trunc),
        .cfg_en(cfg_en), .cfg_crc_chk_off(cfg_crc_chk_off),
        .cfg_promisc_uc(cfg_promisc_uc), .cfg_promisc_mc(cfg_promisc_mc),
        .cfg_pass_pause(cfg_pass_pause), .cfg_strip_fcs(cfg_strip_fcs),
        .cfg_max_len(cfg_max_len), .cfg_station(cfg_station),
        .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof), .out_eof(out_eof),
        .ev_valid(ev_valid), .ev_ok(ev_ok), .ev_drop(ev_drop), .ev_crc(ev_crc),
        .ev_pause(ev_pause), .ev_bcast(ev_bcast), .ev_mcast(ev_mcast), .ev_bytes(ev_bytes)
    );

    always @(negedge clk) begin
        if (out_valid) begin
            got.push_back(out_data);
            got_sof.push_back(out_sof);
            got_eof.push_back(out_eof);
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic build(logic [47:0] da, logic [15:0] et, logic [15:0] op, int len);
        frm.delete();
        for (int i = 0; i < len; i++) begin
            logic [7:0] b;
            b = 8'(i) ^ 8'h5A;
            if (i < 6)        b = da[8*(5-i) +: 8];
            else if (i < 12)  b = 8'h0A + 8'(i);
            else if (i == 12) b = et[15:8];
            else if (i == 13) b = et[7:0];
            else if (i == 14) b = op[15:8];
            else if (i == 15) b = op[7:0];
            frm.push_back(b);
        end
    endtask

    // drives frm, checks the event and the output burst
    task automatic run_frame(string req, bit crc, bit trunc, int off_at, bit exp_ev,
                             bit exp_ok, bit exp_crc, bit exp_pause, bit exp_bc,
                             bit exp_mc, int exp_out);
        got.delete(); got_sof.delete(); got_eof.delete();
        for (int i = 0; i < frm.size(); i++) begin
            @(negedge clk);
            if (i == off_at) cfg_en = 1'b0;
            in_valid   = 1'b1;
            in_data    = frm[i];
            in_sof     = (i == 0);
            in_eof     = (i == frm.size() - 1);
            in_crc_err = crc && in_eof;
            in_trunc   = trunc && in_eof;
        end
        @(negedge clk);
        in_valid = 0; in_sof = 0; in_eof = 0; in_crc_err = 0; in_trunc = 0;
        chk({req, " ev_valid"}, 32'(ev_valid), 32'(exp_ev));
        if (exp_ev) begin
            chk({req, " ev_ok"},    32'(ev_ok),    32'(exp_ok));
            chk({req, " ev_drop"},  32'(ev_drop),  32'(!exp_ok));
            chk({req, " ev_crc"},   32'(ev_crc),   32'(exp_crc));
            chk({req, " ev_pause"}, 32'(ev_pause), 32'(exp_pause));
            chk({req, " ev_bcast"}, 32'(ev_bcast), 32'(exp_bc));
            chk({req, " ev_mcast"}, 32'(ev_mcast), 32'(exp_mc));
            chk({req, " ev_bytes"}, 32'(ev_bytes), 32'(frm.size()));
        end
        @(negedge clk);
        chk({req, " single strobe"}, 32'(ev_valid), 32'(0));
        repeat (frm.size() + 8) @(negedge clk);
        chk({req, " out count"}, 32'(got.size()), 32'(exp_out));
        if (got.size() == exp_out && exp_out > 0) begin
            bit same = 1;
            for (int i = 0; i < exp_out; i++) if (got[i] !== frm[i]) same = 0;
            chk({req, " out bytes"}, 32'(same), 32'(1));
            chk({req, " out sof"}, 32'(got_sof[0]), 32'(1));
            chk({req, " out eof"}, 32'(got_eof[exp_out-1]), 32'(1));
        end
        cfg_en = 1'b1;
    endtask

    task automatic t_reset();
        chk("R1 out_valid", 32'(out_valid), 32'(0));
        chk("R1 ev_valid",  32'(ev_valid),  32'(0));
    endtask

    task automatic t_forward();
        build(STA, 16'h0800, 16'h4500, 64);
        run_frame("R2 unicast match", 0, 0, -1, 1, 1, 0, 0, 0, 0, 64);
        build(STA, 16'h0800, 16'h4500, 100);
        run_frame("R2 longer frame", 0, 0, -1, 1, 1, 0, 0, 0, 0, 100);
    endtask

    task automatic t_strip();
        cfg_strip_fcs = 1;
        build(STA, 16'h0800, 16'h4500, 70);
        run_frame("R3 strip fcs", 0, 0, -1, 1, 1, 0, 0, 0, 0, 66);
        cfg_strip_fcs = 0;
    endtask

    task automatic t_crc();
        build(STA, 16'h0800, 16'h4500, 64);
        run_frame("R4 crc bad checked", 1, 0, -1, 1, 0, 1, 0, 0, 0, 0);
        cfg_crc_chk_off = 1;
        run_frame("R4 crc bad unchecked", 1, 0, -1, 1, 1, 1, 0, 0, 0, 64);
        cfg_crc_chk_off = 0;
    endtask

    task automatic t_trunc();
        build(STA, 16'h0800, 16'h4500, 64);
        run_frame("R5 truncated", 0, 1, -1, 1, 0, 1, 0, 0, 0, 0);
    endtask

    task automatic t_unicast();
        build(OTHER, 16'h0800, 16'h4500, 64);
        run_frame("R6 unicast mismatch", 0, 0, -1, 1, 0, 0, 0, 0, 0, 0);
        cfg_promisc_uc = 1;
        run_frame("R6 promisc unicast", 0, 0, -1, 1, 1, 0, 0, 0, 0, 64);
        cfg_promisc_uc = 0;
    endtask

    task automatic t_group();
        build(MCAST, 16'h0800, 16'h4500, 64);
        run_frame("R7 multicast blocked", 0, 0, -1, 1, 0, 0, 0, 0, 1, 0);
        cfg_promisc_mc = 1;
        run_frame("R7 promisc multicast", 0, 0, -1, 1, 1, 0, 0, 0, 1, 64);
        cfg_promisc_mc = 0;
        build(BCAST, 16'h0800, 16'h4500, 64);
        run_frame("R7 broadcast", 0, 0, -1, 1, 1, 0, 0, 1, 0, 64);
    endtask

    task automatic t_pause();
        build(PDA, 16'h8808, 16'h0001, 64);
        run_frame("R8 pause blocked", 0, 0, -1, 1, 0, 0, 1, 0, 1, 0);
        cfg_pass_pause = 1;
        run_frame("R8 pause passed", 0, 0, -1, 1, 1, 0, 1, 0, 1, 64);
        build(PDA, 16'h8808, 16'h0002, 64);
        run_frame("R8 other opcode", 0, 0, -1, 1, 0, 0, 0, 0, 1, 0);
        cfg_pass_pause = 0;
    endtask

    task automatic t_length();
        cfg_max_len = 14'd100;
        build(STA, 16'h0800, 16'h4500, 63);
        run_frame("R9 runt 63", 0, 0, -1, 1, 0, 0, 0, 0, 0, 0);
        build(STA, 16'h0800, 16'h4500, 64);
        run_frame("R9 min 64", 0, 0, -1, 1, 1, 0, 0, 0, 0, 64);
        build(STA, 16'h0800, 16'h4500, 118);
        run_frame("R9 max 118", 0, 0, -1, 1, 1, 0, 0, 0, 0, 118);
        build(STA, 16'h0800, 16'h4500, 119);
        run_frame("R9 over 119 R11", 0, 0, -1, 1, 0, 0, 0, 0, 0, 0);
        cfg_max_len = 14'd1500;
    endtask

    task automatic t_enable();
        build(STA, 16'h0800, 16'h4500, 64);
        run_frame("R10 disabled at start", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        run_frame("R10 disabled mid frame", 0, 0, 10, 1, 1, 0, 0, 0, 0, 64);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_forward();
        t_strip();
        t_crc();
        t_trunc();
        t_unicast();
        t_group();
        t_pause();
        t_length();
        t_enable();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule